// File: doc/BRIEF.md
# Power-Management Control Register Bank

This block is the byte-wide register file of a power-management companion device. A serial-bus slave front end presents it with three byte-level events: a start of a write transfer, a received data byte and a request for a byte to send. The first byte after a write start loads an internal register pointer. Every later byte written lands at the pointer, and every byte read is taken from it. The pointer steps by one after each such access, so software can stream through neighbouring registers in one transfer.

The bank holds core-voltage, DC-DC, linear-regulator, sleep, oscillator, detect, GPIO, pull-up, card-interface and debounce controls. Most registers keep only their implemented bits. Three core-voltage registers clamp the stored code to a ceiling. Some addresses return synthesized values: a fixed revision, an oscillator-good flag and a merged GPIO input view. One register stores a constant whatever is written to it. A write to the device-off register with bit 0 set returns the whole bank to its defaults. Three GPIO pins follow the output bits of lines set as outputs, and hold their level while a line is set as an input.

Top module: `pmc_regbank`

## Requirements
- R1: After `xfer_start`, the first `wr_valid` byte loads the pointer. Each later written byte is stored at the pointer, and each `rd_req` returns on `rd_data`, one cycle later, the byte at the pointer. After either access the pointer steps by one.
- R2: Address 0x01 always reads `REV_CODE` (default 0x22), and writes to it change nothing.
- R3: At 0x04 and 0x05 a write stores min(d & 0x1F, 0x12). At 0x02 a write stores (d & 0x0E) | min(d & 0x1F, 0x12). Reset values are 0x0C at 0x02, 0x02 at 0x04 and 0x0C at 0x05.
- R4: The oscillator register at 0x15 keeps bits 2:0 and resets to 0x01. Reads of it always have bit 7 set.
- R5: Writing a byte with bit 0 set to 0x14 returns every stored register to its reset value. A byte with bit 0 clear has no effect, and 0x14 reads 0x00.
- R6: Any write to 0x20 stores 0x0D whatever the data. The reset value is 0x00.
- R7: The GPIO direction register at 0x1D keeps the bits of mask 0x67 and resets to 0x07. A 1 in bit i makes line i an input. The output register at 0x1F keeps bits 2:0 and resets to 0x00.
- R8: Address 0x1E reads {5'b0, gpio_in | (~dir[2:0] & out[2:0])}.
- R9: Pin `gpio_pin[i]` takes output bit i whenever line i is an output after a write. While line i is an input, the pin holds its level. All pins reset to 0.
- R10: The detect register at 0x16 keeps mask 0x7F and resets to 0x09. The debounce register at 0x3A keeps mask 0x3F and resets to 0x05. Regulator register 0x0B keeps mask 0x7F and resets to 0x7E.
- R11: Unmapped addresses and 0x39 read 0x00. Writes to them store nothing, but the pointer still steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_start | input | 1 | Start of a write transfer; the next written byte is the pointer |
| wr_valid | input | 1 | A received byte is present on wr_data |
| wr_data | input | 8 | Received byte |
| rd_req | input | 1 | Request for the byte at the pointer |
| rd_data | output | 8 | Byte read, valid the cycle after rd_req |
| gpio_in | input | 3 | External GPIO input levels |
| gpio_pin | output | 3 | Driven GPIO pin levels |

## Verification
The shaping of written data is tried with all-ones bytes, bytes just above and below the 0x12 ceiling, and data with zero in the low bits. This separates masking, clamping, the OR-merge at 0x02 and the constant store. Bursts that cross mapped and unmapped addresses show whether the pointer steps on every access, including ignored ones. The GPIO tests change direction and output bits one at a time with fixed input levels. This separates merged reads from plain storage and shows that pins hold while their line is an input. Writes to the device-off register with bit 0 clear and then set show the reset is gated by that bit alone.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  localparam int BYTE_W  = 8;
  localparam int GPIO_N  = 3;
  localparam int NSLOT   = 31;

  localparam logic [7:0] A_REV     = 8'h01;
  localparam logic [7:0] A_DEVOFF  = 8'h14;
  localparam logic [7:0] A_GPIN    = 8'h1E;
  localparam logic [7:0] A_CARDST  = 8'h39;
  localparam logic [7:0] CLAMP_MAX = 8'h12;

  localparam int S_CORE1 = 0;
  localparam int S_CORE3 = 2;
  localparam int S_CORE4 = 3;
  localparam int S_REG0B = 9;
  localparam int S_OSC   = 18;
  localparam int S_DET   = 19;
  localparam int S_DIR   = 20;
  localparam int S_OUT   = 21;
  localparam int S_BBK   = 22;
  localparam int S_DEB   = 30;

  typedef enum logic [1:0] {
    K_MASK     = 2'd0,
    K_CLAMP    = 2'd1,
    K_CLAMP_OR = 2'd2,
    K_CONST    = 2'd3
  } wkind_e;

  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] mask;
    logic [7:0] rstv;
    wkind_e     kind;
  } slot_t;

  function automatic slot_t mk(input logic [7:0] a, input logic [7:0] m,
                               input logic [7:0] r, input wkind_e k);
    slot_t s;
    s.addr = a; s.mask = m; s.rstv = r; s.kind = k;
    return s;
  endfunction

  // Storage slots: address, kept-bit mask (or constant), reset value, write kind.
  function automatic slot_t slot_desc(input int i);
    slot_t s;
    case (i)
      0:  s = mk(8'h02, 8'hFF, 8'h0C, K_CLAMP_OR);
      1:  s = mk(8'h03, 8'hFF, 8'h05, K_MASK);
      2:  s = mk(8'h04, 8'hFF, 8'h02, K_CLAMP);
      3:  s = mk(8'h05, 8'hFF, 8'h0C, K_CLAMP);
      4:  s = mk(8'h06, 8'h03, 8'h03, K_MASK);
      5:  s = mk(8'h07, 8'h3F, 8'h33, K_MASK);
      6:  s = mk(8'h08, 8'h07, 8'h03, K_MASK);
      7:  s = mk(8'h09, 8'h07, 8'h00, K_MASK);
      8:  s = mk(8'h0A, 8'hFF, 8'h95, K_MASK);
      9:  s = mk(8'h0B, 8'h7F, 8'h7E, K_MASK);
      10: s = mk(8'h0C, 8'h03, 8'h00, K_MASK);
      11: s = mk(8'h0D, 8'h03, 8'h00, K_MASK);
      12: s = mk(8'h0E, 8'h03, 8'h03, K_MASK);
      13: s = mk(8'h0F, 8'h03, 8'h00, K_MASK);
      14: s = mk(8'h10, 8'h03, 8'h00, K_MASK);
      15: s = mk(8'h11, 8'h03, 8'h00, K_MASK);
      16: s = mk(8'h12, 8'hFF, 8'h00, K_MASK);
      17: s = mk(8'h13, 8'hFF, 8'h00, K_MASK);
      18: s = mk(8'h15, 8'h07, 8'h01, K_MASK);
      19: s = mk(8'h16, 8'h7F, 8'h09, K_MASK);
      20: s = mk(8'h1D, 8'h67, 8'h07, K_MASK);
      21: s = mk(8'h1F, 8'h07, 8'h00, K_MASK);
      22: s = mk(8'h20, 8'h0D, 8'h00, K_CONST);
      23: s = mk(8'h32, 8'hFF, 8'h00, K_MASK);
      24: s = mk(8'h33, 8'h1F, 8'h00, K_MASK);
      25: s = mk(8'h34, 8'hFF, 8'h00, K_MASK);
      26: s = mk(8'h35, 8'h1F, 8'h00, K_MASK);
      27: s = mk(8'h36, 8'h7F, 8'h03, K_MASK);
      28: s = mk(8'h37, 8'hFF, 8'hC0, K_MASK);
      29: s = mk(8'h38, 8'h0F, 8'h00, K_MASK);
      default: s = mk(8'h3A, 8'h3F, 8'h05, K_MASK);
    endcase
    return s;
  endfunction

endpackage

// File: rtl/pmc_ptr.sv
module pmc_ptr
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_start,
  input  logic              wr_valid,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_req,
  output logic [BYTE_W-1:0] ptr,
  output logic              data_we,
  output logic              data_re
);

  logic              want_addr_q, want_addr_n;
  logic [BYTE_W-1:0] ptr_q, ptr_n;
  logic              ptr_en;

  assign data_we = wr_valid && !xfer_start && !want_addr_q;
  assign data_re = rd_req && !xfer_start && !wr_valid;
  assign ptr     = ptr_q;

  always_comb begin
    want_addr_n = want_addr_q;
    ptr_n       = ptr_q;
    ptr_en      = 1'b0;
    if (xfer_start) begin
      want_addr_n = 1'b1;
    end else if (wr_valid) begin
      ptr_en = 1'b1;
      if (want_addr_q) begin
        ptr_n       = wr_data;
        want_addr_n = 1'b0;
      end else begin
        ptr_n = ptr_q + 1'b1;
      end
    end else if (rd_req) begin
      ptr_en = 1'b1;
      ptr_n  = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_addr_q <= 1'b0;
      ptr_q       <= '0;
    end else begin
      want_addr_q <= want_addr_n;
      if (ptr_en) ptr_q <= ptr_n;
    end
  end

  assert_ptr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we || data_re) |=> (ptr_q == $past(ptr_q) + 8'd1));

endmodule

// File: rtl/pmc_gpio.sv
module pmc_gpio
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GPIO_N-1:0] dir_n,
  input  logic [GPIO_N-1:0] out_n,
  input  logic [GPIO_N-1:0] dir_q,
  output logic [GPIO_N-1:0] pin
);

  logic [GPIO_N-1:0] pin_q;
  assign pin = pin_q;

  for (genvar g = 0; g < GPIO_N; g++) begin : g_line
    logic drive_en;
    assign drive_en = !dir_n[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pin_q[g] <= 1'b0;
      else if (drive_en) pin_q[g] <= out_n[g];
    end

    assert_pin_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_q[g] && $past(dir_q[g])) |-> $stable(pin_q[g]));
  end

endmodule

// File: rtl/pmc_regbank.sv
module pmc_regbank
  import pmc_pkg::*;
#(
  parameter logic [7:0] REV_CODE = 8'h22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_start,
  input  logic              wr_valid,
  input  logic [7:0]        wr_data,
  input  logic              rd_req,
  output logic [7:0]        rd_data,
  input  logic [2:0]        gpio_in,
  output logic [2:0]        gpio_pin
);

  // reset: asserted asynchronously, released on the clock
  logic rst_s1_q, rst_s2_q, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_i = rst_s2_q;

  logic [BYTE_W-1:0] ptr;
  logic              data_we, data_re;

  pmc_ptr u_ptr (
    .clk        (clk),
    .rst_n      (rst_i),
    .xfer_start (xfer_start),
    .wr_valid   (wr_valid),
    .wr_data    (wr_data),
    .rd_req     (rd_req),
    .ptr        (ptr),
    .data_we    (data_we),
    .data_re    (data_re)
  );

  logic soft_rst;
  assign soft_rst = data_we && (ptr == A_DEVOFF) && wr_data[0];

  function automatic logic [7:0] shape(input slot_t s, input logic [7:0] d);
    logic [7:0] low5, clip;
    low5 = d & 8'h1F;
    clip = (low5 > CLAMP_MAX) ? CLAMP_MAX : low5;
    case (s.kind)
      K_CLAMP:    return clip;
      K_CLAMP_OR: return (d & 8'h0E) | clip;
      K_CONST:    return s.mask;
      default:    return d & s.mask;
    endcase
  endfunction

  logic [7:0] regs_q [NSLOT];
  logic [7:0] regs_n [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    localparam slot_t DESC = slot_desc(g);
    logic hit, en;
    assign hit = data_we && (ptr == DESC.addr);
    assign en  = hit || soft_rst;

    always_comb begin
      if (soft_rst) regs_n[g] = DESC.rstv;
      else          regs_n[g] = shape(DESC, wr_data);
    end

    always_ff @(posedge clk or negedge rst_i) begin
      if (!rst_i)  regs_q[g] <= DESC.rstv;
      else if (en) regs_q[g] <= regs_n[g];
    end
  end

  // GPIO pin drivers see the post-write direction and output values
  logic [GPIO_N-1:0] dir_nx, out_nx;
  always_comb begin
    dir_nx = (g_slot[S_DIR].en) ? regs_n[S_DIR][GPIO_N-1:0] : regs_q[S_DIR][GPIO_N-1:0];
    out_nx = (g_slot[S_OUT].en) ? regs_n[S_OUT][GPIO_N-1:0] : regs_q[S_OUT][GPIO_N-1:0];
  end

  pmc_gpio u_gpio (
    .clk   (clk),
    .rst_n (rst_i),
    .dir_n (dir_nx),
    .out_n (out_nx),
    .dir_q (regs_q[S_DIR][GPIO_N-1:0]),
    .pin   (gpio_pin)
  );

  // read path
  logic [7:0] rd_val;
  always_comb begin
    rd_val = 8'h00;
    for (int i = 0; i < NSLOT; i++) begin
      if (ptr == slot_desc(i).addr) rd_val = regs_q[i];
    end
    if (ptr == slot_desc(S_OSC).addr) rd_val = regs_q[S_OSC] | 8'h80;
    if (ptr == A_REV)                 rd_val = REV_CODE;
    if (ptr == A_GPIN)
      rd_val = {5'b0, gpio_in | (~regs_q[S_DIR][GPIO_N-1:0] & regs_q[S_OUT][GPIO_N-1:0])};
  end

  logic [7:0] rd_q;
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)       rd_q <= '0;
    else if (data_re) rd_q <= rd_val;
  end
  assign rd_data = rd_q;

  assert_rev_R2: assert property (@(posedge clk) disable iff (!rst_i)
    (data_re && ptr == A_REV) |=> (rd_data == REV_CODE));

  assert_clamp_R3: assert property (@(posedge clk) disable iff (!rst_i)
    (regs_q[S_CORE3] <= CLAMP_MAX) && (regs_q[S_CORE4] <= CLAMP_MAX));

  assert_osc_flag_R4: assert property (@(posedge clk) disable iff (!rst_i)
    (data_re && ptr == slot_desc(S_OSC).addr) |=> rd_data[7]);

  assert_devoff_R5: assert property (@(posedge clk) disable iff (!rst_i)
    soft_rst |=> (regs_q[S_OSC] == 8'h01 && regs_q[S_DIR] == 8'h07 &&
                  regs_q[S_DEB] == 8'h05));

  assert_const_R6: assert property (@(posedge clk) disable iff (!rst_i)
    (regs_q[S_BBK] == 8'h00) || (regs_q[S_BBK] == 8'h0D));

  assert_dirmask_R7: assert property (@(posedge clk) disable iff (!rst_i)
    ((regs_q[S_DIR] & 8'h98) == 8'h00) && ((regs_q[S_OUT] & 8'hF8) == 8'h00));

  assert_zero_read_R11: assert property (@(posedge clk) disable iff (!rst_i)
    (data_re && (ptr == A_CARDST || ptr == A_DEVOFF)) |=> (rd_data == 8'h00));

endmodule

// File: tb/pmc_regbank_tb.sv
module pmc_regbank_tb_top;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       xfer_start = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_req = 1'b0;
  logic [7:0] rd_data;
  logic [2:0] gpio_in = 3'b000;
  logic [2:0] gpio_pin;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmc_regbank dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_start (xfer_start),
    .wr_valid   (wr_valid),
    .wr_data    (wr_data),
    .rd_req     (rd_req),
    .rd_data    (rd_data),
    .gpio_in    (gpio_in),
    .gpio_pin   (gpio_pin)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic begin_xfer(input logic [7:0] addr);
    @(negedge clk); xfer_start = 1'b1;
    @(negedge clk); xfer_start = 1'b0; wr_valid = 1'b1; wr_data = addr;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic put(input logic [7:0] d);
    @(negedge clk); wr_valid = 1'b1; wr_data = d;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic get(output logic [7:0] d);
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0; d = rd_data;
  endtask

  task automatic wr1(input logic [7:0] a, input logic [7:0] d);
    begin_xfer(a); put(d);
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] v;
    begin_xfer(a); get(v); check(req, v, exp);
  endtask

  task automatic t_reset;
    rd_chk("R4 osc reset", 8'h15, 8'h81);
    rd_chk("R10 detect reset", 8'h16, 8'h09);
    rd_chk("R10 debounce reset", 8'h3A, 8'h05);
    rd_chk("R7 dir reset", 8'h1D, 8'h07);
    rd_chk("R3 core1 reset", 8'h02, 8'h0C);
    rd_chk("R6 const reg reset", 8'h20, 8'h00);
    check("R9 pins reset", {5'b0, gpio_pin}, 8'h00);
  endtask

  task automatic t_burst;
    logic [7:0] a, b;
    begin_xfer(8'h12); put(8'hA5); put(8'h5A);
    begin_xfer(8'h12); get(a); get(b);
    check("R1 burst first", a, 8'hA5);
    check("R1 burst second", b, 8'h5A);
  endtask

  task automatic t_rev;
    wr1(8'h01, 8'h77);
    rd_chk("R2 revision", 8'h01, 8'h22);
  endtask

  task automatic t_clamp;
    wr1(8'h04, 8'hFF); rd_chk("R3 clamp high", 8'h04, 8'h12);
    wr1(8'h05, 8'h07); rd_chk("R3 below ceiling", 8'h05, 8'h07);
    wr1(8'h02, 8'h1F); rd_chk("R3 or-merge 1F", 8'h02, 8'h1E);
    wr1(8'h02, 8'h15); rd_chk("R3 or-merge 15", 8'h02, 8'h16);
  endtask

  task automatic t_masks;
    wr1(8'h16, 8'hFF); rd_chk("R10 detect mask", 8'h16, 8'h7F);
    wr1(8'h3A, 8'hFF); rd_chk("R10 debounce mask", 8'h3A, 8'h3F);
    wr1(8'h0B, 8'hFF); rd_chk("R10 reg 0B mask", 8'h0B, 8'h7F);
    wr1(8'h15, 8'hFE); rd_chk("R4 osc mask", 8'h15, 8'h86);
    wr1(8'h20, 8'h00); rd_chk("R6 const store", 8'h20, 8'h0D);
  endtask

  task automatic t_gpio;
    logic [7:0] v;
    wr1(8'h1D, 8'hFF); rd_chk("R7 dir mask", 8'h1D, 8'h67);
    wr1(8'h1F, 8'hFF); rd_chk("R7 out mask", 8'h1F, 8'h07);
    check("R9 inputs hold pins", {5'b0, gpio_pin}, 8'h00);
    wr1(8'h1D, 8'h06);
    check("R9 line0 drives", {5'b0, gpio_pin}, 8'h01);
    wr1(8'h1D, 8'h07);
    wr1(8'h1F, 8'h00);
    check("R9 input holds level", {5'b0, gpio_pin}, 8'h01);
    wr1(8'h1D, 8'h06);
    check("R9 line0 follows out", {5'b0, gpio_pin}, 8'h00);
    gpio_in = 3'b001;
    wr1(8'h1D, 8'h05); wr1(8'h1F, 8'h03);
    check("R9 line1 drives", {5'b0, gpio_pin}, 8'h02);
    begin_xfer(8'h1E); get(v);
    check("R8 merged read", v, 8'h03);
    gpio_in = 3'b100;
    begin_xfer(8'h1E); get(v);
    check("R8 input-only bit", v, 8'h06);
    gpio_in = 3'b000;
  endtask

  task automatic t_unmapped;
    logic [7:0] a, b;
    begin_xfer(8'h39); put(8'h11); put(8'h22);
    begin_xfer(8'h39); get(a); get(b);
    check("R11 0x39 reads zero", a, 8'h00);
    check("R11 pointer stepped past ignored write", b, 8'h22);
    wr1(8'h25, 8'hFF);
    rd_chk("R11 unmapped read", 8'h25, 8'h00);
  endtask

  task automatic t_devoff;
    wr1(8'h15, 8'h06);
    wr1(8'h14, 8'h02);
    rd_chk("R5 bit0 clear no reset", 8'h15, 8'h86);
    rd_chk("R5 devoff reads zero", 8'h14, 8'h00);
    wr1(8'h14, 8'h01);
    rd_chk("R5 osc back to default", 8'h15, 8'h81);
    rd_chk("R5 debounce back to default", 8'h3A, 8'h05);
    rd_chk("R5 const back to default", 8'h20, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_burst();
    t_rev();
    t_clamp();
    t_masks();
    t_gpio();
    t_unmapped();
    t_devoff();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule